// File: doc/BRIEF.md
# NAND Flash Host Register Block

This block sits between a simple CPU register bus and a raw 8-bit NAND flash device. A control register drives the flash command, address, chip-enable and write-protect pins, and also shows the live ready/busy state of the device. A data port passes bytes to or from the flash. A byte written to the data port is sent out with a one-cycle write strobe. A read of the data port pulls one byte from the flash, or two bytes for a wide read, using a one-cycle read strobe for each byte.

Every byte that crosses the data port, in either direction, passes through an ECC accumulator. The accumulator keeps a byte count, six column-parity bits and two banks of line parity. The line-parity banks are indexed by the byte's position within a 256-byte block. Software reads the accumulator through three registers and the counter register, and clears it by writing the clear strobe. The line-parity bits reach software interleaved: one register carries the upper halves of both banks and the other carries the lower halves.

The bus carries one access at a time. `bus_req` is a one-cycle pulse, raised only when no earlier access is still waiting for its `bus_ack`.

Top module: `nand_host_regs`

## Requirements
- R1: The control register at offset 0x00 drives the flash pins. Bit0 drives `nand_cle` and bit1 drives `nand_ale`. Bit2 and bit3 enable chip 0 and chip 1, and `nand_ce_n[0]` and `nand_ce_n[1]` are the inverse of those bits. Bit4 turns write protect on, and `nand_wp_n` is its inverse. The pins change one cycle after the write request.
- R2: A read of offset 0x00 returns the stored control bits with bit5 replaced by the `nand_rdy` level seen at the request. Bit5 of a control write is discarded.
- R3: A write to the data port at offset 0x04 places `bus_wdata[7:0]` on `nand_dout` and pulses `nand_we` for exactly one cycle, in the cycle after the request.
- R4: A narrow read of offset 0x04 (`bus_wide`=0) pulses `nand_re` for one cycle. It returns the sampled flash byte in `bus_rdata[7:0]`, with all other bits zero, and `bus_ack` rises two cycles after the request.
- R5: A wide read of offset 0x04 (`bus_wide`=1) pulses `nand_re` in two consecutive cycles. It returns the first byte in bits 7:0 and the second in bits 23:16, with all other bits zero, and `bus_ack` rises three cycles after the request.
- R6: Every data-port byte, whether written or read, increments the ECC byte count. Offset 0x14 returns the low 8 bits of that count, so the value wraps after 256 bytes.
- R7: The column parity at offset 0x10 holds six bits in bits 5:0. For j = 0..2, bit 2j is the running XOR of the data bits whose bit index has bit j clear, and bit 2j+1 is the running XOR of the data bits whose bit index has bit j set.
- R8: Each data byte's XOR parity p is folded into two 8-bit line-parity banks, even and odd. For each k, the byte index (count mod 256, taken before the increment) selects a bank: p goes into odd[k] when bit k of the index is 1, and into even[k] when it is 0.
- R9: Offset 0x08 returns {odd[7],even[7],odd[6],even[6],odd[5],even[5],odd[4],even[4]} (MSB first). Offset 0x0C returns the same interleave built from bits 3:0.
- R10: A write of any value to offset 0x18 clears the count, the column parity and both line-parity banks.
- R11: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 returns zero, and this includes the write-only offset 0x18. A write to any offset other than 0x00, 0x04 and 0x18 leaves the pins, the flash strobes and the ECC state unchanged.
- R12: After reset the control register is zero. Both `nand_ce_n` bits and `nand_wp_n` are 1, `nand_cle` and `nand_ale` are 0, and all ECC registers read zero.
- R13: Every access other than a data-port read is acknowledged by a one-cycle `bus_ack` in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | Wide (two-byte) data-port read |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Access complete |
| bus_rdata | output | DATA_W | Read data, valid while bus_ack is high |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_we | output | 1 | Write strobe for nand_dout |
| nand_re | output | 1 | Read strobe; nand_din is sampled in the same cycle |
| nand_dout | output | 8 | Byte to the flash |
| nand_din | input | 8 | Byte from the flash |
| nand_rdy | input | 1 | Flash ready (1) or busy (0) |

## Verification
The bound checker watches the pin-level rules on every cycle. These are: control writes reaching the pins, the ready bit in control reads, the data-write strobe and byte, the first read strobe of a data read, strobe exclusivity, and silent writes to unused offsets. The ECC arithmetic is checked only by the bench's scenarios, which compare against a model built from the requirements. Those scenarios cover column and line parity after mixed reads and writes, the interleaved line-parity layout, the count wrapping past 256 bytes, clearing with arbitrary data, and the byte placement of wide reads.

// File: rtl/nfh_pkg.sv
package nfh_pkg;
   localparam int BYTE_W = 8;
   localparam int COL_W  = 6;

   localparam logic [5:0] OFS_CTL  = 6'h00;
   localparam logic [5:0] OFS_DATA = 6'h04;
   localparam logic [5:0] OFS_LPLO = 6'h08;
   localparam logic [5:0] OFS_LPHI = 6'h0C;
   localparam logic [5:0] OFS_COL  = 6'h10;
   localparam logic [5:0] OFS_CNT  = 6'h14;
   localparam logic [5:0] OFS_CLR  = 6'h18;

   localparam int CB_CLE = 0;
   localparam int CB_ALE = 1;
   localparam int CB_CE0 = 2;
   localparam int CB_CE1 = 3;
   localparam int CB_WP  = 4;
   localparam int CB_RDY = 5;

   typedef enum logic [1:0] {ST_IDLE, ST_RD_LO, ST_RD_HI} rd_state_e;
endpackage

// File: rtl/nfh_ctl_reg.sv
module nfh_ctl_reg
   import nfh_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_val,
   input  logic              rdy,
   output logic [BYTE_W-1:0] rd_val,
   output logic [1:0]        ce_n,
   output logic              cle,
   output logic              ale,
   output logic              wp_n
);
   logic [BYTE_W-1:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (wr_en) begin
         ctl_q         <= wr_val;
         ctl_q[CB_RDY] <= 1'b0;
      end
   end

   always_comb begin
      rd_val         = ctl_q;
      rd_val[CB_RDY] = rdy;
   end

   assign cle  = ctl_q[CB_CLE];
   assign ale  = ctl_q[CB_ALE];
   assign ce_n = ~{ctl_q[CB_CE1], ctl_q[CB_CE0]};
   assign wp_n = ~ctl_q[CB_WP];
endmodule

// File: rtl/nfh_ecc_acc.sv
module nfh_ecc_acc
   import nfh_pkg::*;
#(
   parameter int LINE_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              upd,
   input  logic [BYTE_W-1:0] din,
   output logic [LINE_W-1:0] lp_even,
   output logic [LINE_W-1:0] lp_odd,
   output logic [COL_W-1:0]  col,
   output logic [CNT_W-1:0]  cnt
);
   localparam int IDX_BITS = $clog2(BYTE_W);

   logic [COL_W-1:0]  col_term;
   logic [LINE_W-1:0] idx;
   logic              par;

   always_comb begin
      col_term = '0;
      for (int j = 0; j < IDX_BITS; j++) begin
         for (int b = 0; b < BYTE_W; b++) begin
            if (((b >> j) & 1) != 0)
               col_term[2*j+1] = col_term[2*j+1] ^ din[b];
            else
               col_term[2*j] = col_term[2*j] ^ din[b];
         end
      end
   end

   assign par = ^din;
   assign idx = cnt[LINE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lp_even <= '0;
         lp_odd  <= '0;
         col     <= '0;
         cnt     <= '0;
      end else if (clr) begin
         lp_even <= '0;
         lp_odd  <= '0;
         col     <= '0;
         cnt     <= '0;
      end else if (upd) begin
         lp_odd  <= lp_odd  ^ ({LINE_W{par}} & idx);
         lp_even <= lp_even ^ ({LINE_W{par}} & ~idx);
         col     <= col ^ col_term;
         cnt     <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/nfh_lp_interleave.sv
module nfh_lp_interleave #(
   parameter int LINE_W   = 8,
   parameter bit SRC_HIGH = 1'b0
) (
   input  logic [LINE_W-1:0] even_bank,
   input  logic [LINE_W-1:0] odd_bank,
   output logic [LINE_W-1:0] packed_out
);
   localparam int HALF = LINE_W / 2;
   localparam int BASE = SRC_HIGH ? HALF : 0;

   for (genvar i = 0; i < HALF; i++) begin : g_pair
      assign packed_out[2*i]   = even_bank[BASE+i];
      assign packed_out[2*i+1] = odd_bank[BASE+i];
   end
endmodule

// File: rtl/nand_host_regs.sv
module nand_host_regs
   import nfh_pkg::*;
#(
   parameter int ADDR_W       = 6,
   parameter int DATA_W       = 32,
   parameter int LINE_W       = 8,
   parameter int CNT_W        = 16,
   parameter bit WIDE_READ_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic              bus_wide,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_ack,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [1:0]        nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_wp_n,
   output logic              nand_we,
   output logic              nand_re,
   output logic [7:0]        nand_dout,
   input  logic [7:0]        nand_din,
   input  logic              nand_rdy
);
   localparam int HI_LSB = 16;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must cover the 64-byte window");
   end
   if (DATA_W < HI_LSB + BYTE_W) begin : g_bad_data
      $error("DATA_W must hold the second byte of a wide read");
   end
   if (LINE_W != BYTE_W || (LINE_W % 2) != 0) begin : g_bad_line
      $error("LINE_W must be an even value equal to the register width");
   end
   if (CNT_W < LINE_W) begin : g_bad_cnt
      $error("CNT_W must be at least LINE_W");
   end

   rd_state_e         st_q;
   logic              wide_q;
   logic              accept;
   logic              wide_sel;
   logic              hit_ctl, hit_data, hit_clr;
   logic [BYTE_W-1:0] ctl_rd;
   logic [LINE_W-1:0] lp_even, lp_odd, lp_lo_reg, lp_hi_reg;
   logic [COL_W-1:0]  col;
   logic [CNT_W-1:0]  cnt;
   logic              ecc_upd;
   logic [BYTE_W-1:0] ecc_byte;
   logic [DATA_W-1:0] rd_mux;

   if (WIDE_READ_EN) begin : g_wide
      assign wide_sel = bus_wide;
   end else begin : g_narrow
      assign wide_sel = 1'b0;
   end

   assign accept   = bus_req && (st_q == ST_IDLE);
   assign hit_ctl  = (bus_addr == ADDR_W'(OFS_CTL));
   assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
   assign hit_clr  = (bus_addr == ADDR_W'(OFS_CLR));
   assign nand_re  = (st_q != ST_IDLE);

   nfh_ctl_reg u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (accept && bus_we && hit_ctl),
      .wr_val (bus_wdata[BYTE_W-1:0]),
      .rdy    (nand_rdy),
      .rd_val (ctl_rd),
      .ce_n   (nand_ce_n),
      .cle    (nand_cle),
      .ale    (nand_ale),
      .wp_n   (nand_wp_n)
   );

   assign ecc_upd  = (accept && bus_we && hit_data) || nand_re;
   assign ecc_byte = nand_re ? nand_din : bus_wdata[BYTE_W-1:0];

   nfh_ecc_acc #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_ecc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept && bus_we && hit_clr),
      .upd     (ecc_upd),
      .din     (ecc_byte),
      .lp_even (lp_even),
      .lp_odd  (lp_odd),
      .col     (col),
      .cnt     (cnt)
   );

   nfh_lp_interleave #(.LINE_W(LINE_W), .SRC_HIGH(1'b1)) u_lp_lo (
      .even_bank (lp_even),
      .odd_bank  (lp_odd),
      .packed_out(lp_lo_reg)
   );

   nfh_lp_interleave #(.LINE_W(LINE_W), .SRC_HIGH(1'b0)) u_lp_hi (
      .even_bank (lp_even),
      .odd_bank  (lp_odd),
      .packed_out(lp_hi_reg)
   );

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         ADDR_W'(OFS_CTL):  rd_mux[BYTE_W-1:0] = ctl_rd;
         ADDR_W'(OFS_LPLO): rd_mux[LINE_W-1:0] = lp_lo_reg;
         ADDR_W'(OFS_LPHI): rd_mux[LINE_W-1:0] = lp_hi_reg;
         ADDR_W'(OFS_COL):  rd_mux[COL_W-1:0]  = col;
         ADDR_W'(OFS_CNT):  rd_mux[BYTE_W-1:0] = cnt[BYTE_W-1:0];
         default:           rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         wide_q    <= 1'b0;
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
         nand_we   <= 1'b0;
         nand_dout <= '0;
      end else begin
         bus_ack <= 1'b0;
         nand_we <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  if (bus_we) begin
                     bus_ack <= 1'b1;
                     if (hit_data) begin
                        nand_we   <= 1'b1;
                        nand_dout <= bus_wdata[BYTE_W-1:0];
                     end
                  end else if (hit_data) begin
                     st_q   <= ST_RD_LO;
                     wide_q <= wide_sel;
                  end else begin
                     bus_ack   <= 1'b1;
                     bus_rdata <= rd_mux;
                  end
               end
            end
            ST_RD_LO: begin
               bus_rdata               <= '0;
               bus_rdata[BYTE_W-1:0]   <= nand_din;
               if (wide_q)
                  st_q <= ST_RD_HI;
               else begin
                  st_q    <= ST_IDLE;
                  bus_ack <= 1'b1;
               end
            end
            ST_RD_HI: begin
               bus_rdata[HI_LSB +: BYTE_W] <= nand_din;
               st_q    <= ST_IDLE;
               bus_ack <= 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nand_host_regs_chk.sv
module nand_host_regs_chk
   import nfh_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_wide,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ack,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [1:0]        nand_ce_n,
   input logic              nand_cle,
   input logic              nand_ale,
   input logic              nand_wp_n,
   input logic              nand_we,
   input logic              nand_re,
   input logic [7:0]        nand_dout,
   input logic [7:0]        nand_din,
   input logic              nand_rdy
);
   logic is_ctl, is_data, is_wr_target;
   assign is_ctl       = (bus_addr == ADDR_W'(OFS_CTL));
   assign is_data      = (bus_addr == ADDR_W'(OFS_DATA));
   assign is_wr_target = is_ctl || is_data || (bus_addr == ADDR_W'(OFS_CLR));

   // R1
   ctl_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && is_ctl) |=>
         (nand_cle == $past(bus_wdata[CB_CLE]) && nand_ale == $past(bus_wdata[CB_ALE]) &&
          nand_ce_n[0] == !$past(bus_wdata[CB_CE0]) && nand_ce_n[1] == !$past(bus_wdata[CB_CE1]) &&
          nand_wp_n == !$past(bus_wdata[CB_WP])));

   // R2
   rdy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ack && $past(bus_req && !bus_we && is_ctl)) |-> (bus_rdata[CB_RDY] == $past(nand_rdy)));

   // R3
   data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && is_data) |=> (nand_we && nand_dout == $past(bus_wdata[7:0])));

   // R4
   rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && is_data) |=> $rose(nand_re));

   // R4
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_we && nand_re));

   // R11
   undef_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && !is_wr_target) |=>
         ($stable(nand_ce_n) && $stable(nand_cle) && $stable(nand_ale) && $stable(nand_wp_n) && !nand_we));
endmodule

bind nand_host_regs nand_host_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/nand_host_regs_test.sv
module nand_host_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0, wide = 1'b0, rdy = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        ack, nwe, nre, cle, ale, wp_n;
   logic [31:0] rdata;
   logic [1:0]  ce_n;
   logic [7:0]  dout, din;

   int checks = 0, errors = 0;
   int wr_cnt = 0, re_cnt = 0, cyc = 0;
   logic [7:0]  wr_last = '0;
   logic [15:0] rptr = '0;

   logic [5:0] m_col;
   logic [7:0] m_ev, m_od;
   int         m_cnt;

   always #10 clk = ~clk;

   nand_host_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_wide(wide),
      .bus_addr(addr), .bus_wdata(wdata), .bus_ack(ack), .bus_rdata(rdata),
      .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_wp_n(wp_n),
      .nand_we(nwe), .nand_re(nre), .nand_dout(dout), .nand_din(din), .nand_rdy(rdy)
   );

   function automatic logic [7:0] flash_byte(input logic [15:0] p);
      return 8'((p * 16'd73) + 16'd29);
   endfunction
   assign din = flash_byte(rptr);

   always @(posedge clk) begin
      if (nre) begin rptr <= rptr + 1'b1; re_cnt <= re_cnt + 1; end
      if (nwe) begin wr_last <= dout; wr_cnt <= wr_cnt + 1; end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_op(input logic w, input logic wd, input logic [5:0] a,
                         input logic [31:0] d, output logic [31:0] rd, output int lat);
      @(negedge clk);
      req = 1'b1; we = w; wide = wd; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0; lat = 1;
      while (!ack && lat < 20) begin @(negedge clk); lat++; end
      rd = rdata;
      @(negedge clk);
   endtask

   task automatic m_reset();
      m_col = '0; m_ev = '0; m_od = '0; m_cnt = 0;
   endtask

   task automatic m_byte(input logic [7:0] b);
      logic [7:0] idx;
      idx = 8'(m_cnt);
      for (int j = 0; j < 3; j++)
         for (int k = 0; k < 8; k++)
            if (((k >> j) & 1) != 0) m_col[2*j+1] ^= b[k];
            else m_col[2*j] ^= b[k];
      for (int k = 0; k < 8; k++)
         if (idx[k]) m_od[k] ^= ^b; else m_ev[k] ^= ^b;
      m_cnt++;
   endtask

   function automatic logic [31:0] m_lp(input bit upper);
      logic [31:0] r = '0;
      for (int i = 0; i < 4; i++) begin
         r[2*i]   = m_ev[(upper ? 4 : 0) + i];
         r[2*i+1] = m_od[(upper ? 4 : 0) + i];
      end
      return r;
   endfunction

   task automatic chk_ecc(input string tag);
      logic [31:0] r; int l;
      bus_op(1'b0, 1'b0, 6'h08, '0, r, l); chk({tag, " R9 lp low"}, r, m_lp(1'b1));
      bus_op(1'b0, 1'b0, 6'h0C, '0, r, l); chk({tag, " R8 R9 lp high"}, r, m_lp(1'b0));
      bus_op(1'b0, 1'b0, 6'h10, '0, r, l); chk({tag, " R7 column"}, r, {26'd0, m_col});
      bus_op(1'b0, 1'b0, 6'h14, '0, r, l); chk({tag, " R6 count"}, r, 32'(m_cnt & 255));
   endtask

   localparam int NV = 10;
   localparam logic        V_WE  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
   localparam logic [5:0]  V_AD  [NV] = '{6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h3C, 6'h00, 6'h3C, 6'h18};
   localparam logic [31:0] V_WD  [NV] = '{32'h0, 32'h0, 32'hFF, 32'h0, 32'h25, 32'h0, 32'hFF, 32'h0, 32'h0, 32'h0};
   localparam logic        V_RDY [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
   localparam logic [31:0] V_EXP [NV] = '{32'h0, 32'h20, 32'h0, 32'hDF, 32'h0, 32'h25, 32'h0, 32'h05, 32'h0, 32'h0};

   initial begin
      logic [31:0] r;
      int l, re0;
      logic [15:0] p0;
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 ce_n", 32'(ce_n), 32'h3);
      chk("R12 wp_n", 32'(wp_n), 32'h1);
      chk("R12 cle/ale", 32'({cle, ale}), 32'h0);
      chk_ecc("R12 reset");

      // R2 R11 R13 vector table
      for (int v = 0; v < NV; v++) begin
         rdy = V_RDY[v];
         bus_op(V_WE[v], 1'b0, V_AD[v], V_WD[v], r, l);
         chk("R13 ack latency", 32'(l), 32'd1);
         if (!V_WE[v]) chk($sformatf("R2 R11 table entry %0d", v), r, V_EXP[v]);
      end

      // R1 pin mapping
      bus_op(1'b1, 1'b0, 6'h00, 32'h05, r, l);
      chk("R1 pins 0x05", 32'({ce_n, cle, ale, wp_n}), 32'({2'b10, 1'b1, 1'b0, 1'b1}));
      bus_op(1'b1, 1'b0, 6'h00, 32'h1A, r, l);
      chk("R1 pins 0x1A", 32'({ce_n, cle, ale, wp_n}), 32'({2'b01, 1'b0, 1'b1, 1'b0}));
      bus_op(1'b1, 1'b0, 6'h00, 32'h0C, r, l);

      // R3 data writes
      bus_op(1'b1, 1'b0, 6'h04, 32'h1A5, r, l); m_byte(8'hA5);
      chk("R3 dout", 32'(wr_last), 32'hA5);
      chk("R3 one strobe", 32'(wr_cnt), 32'd1);
      bus_op(1'b1, 1'b0, 6'h04, 32'h3C, r, l); m_byte(8'h3C);
      chk("R3 dout second", 32'(wr_last), 32'h3C);
      chk_ecc("R7 R8 after writes");

      // R4 narrow read
      p0 = rptr; re0 = re_cnt;
      bus_op(1'b0, 1'b0, 6'h04, '0, r, l); m_byte(flash_byte(p0));
      chk("R4 byte", r, {24'd0, flash_byte(p0)});
      chk("R4 latency", 32'(l), 32'd2);
      chk("R4 strobes", 32'(re_cnt - re0), 32'd1);

      // R5 wide read
      p0 = rptr; re0 = re_cnt;
      bus_op(1'b0, 1'b1, 6'h04, '0, r, l);
      m_byte(flash_byte(p0)); m_byte(flash_byte(p0 + 1'b1));
      chk("R5 word", r, {8'd0, flash_byte(p0 + 1'b1), 8'd0, flash_byte(p0)});
      chk("R5 latency", 32'(l), 32'd3);
      chk("R5 strobes", 32'(re_cnt - re0), 32'd2);
      chk_ecc("R6 R7 R8 mixed");

      // R11 undefined write leaves ECC alone
      bus_op(1'b1, 1'b0, 6'h14, 32'hFF, r, l);
      bus_op(1'b1, 1'b0, 6'h22, 32'hFF, r, l);
      chk_ecc("R11 after undefined writes");

      // R10 clear with arbitrary data
      bus_op(1'b1, 1'b0, 6'h18, 32'hDEADBEEF, r, l); m_reset();
      chk_ecc("R10 cleared");

      // R6 R8 wrap past 256 bytes
      for (int i = 0; i < 300; i++) begin
         bus_op(1'b1, 1'b0, 6'h04, 32'((i * 13 + 7) & 255), r, l);
         m_byte(8'((i * 13 + 7) & 255));
      end
      chk("R3 write count", 32'(wr_cnt), 32'd302);
      chk_ecc("R6 R8 wrap");
      bus_op(1'b1, 1'b0, 6'h18, 32'h0, r, l); m_reset();
      chk_ecc("R10 clear zero data");
      summary();
   end
endmodule